// File: doc/BRIEF.md
# Word-Line Slice Pulse Sequencer

This block turns one vector of 8-bit unsigned activations into the timed row drive for a single multiply-accumulate pass of a compute-in-memory array. Each activation is cut into three unequal bit-slices: two high bits, then three middle bits, then three low bits. Each slice is applied in a phase of its own as a word-line pulse whose length in clock cycles equals the slice value. All rows share the same phase timing, so their pulses start together and their cell currents add on the bitlines.

Around the pulses the block sequences the analog accumulation path. It clears the integrating capacitor before the high slice and strobes the converter after it. For the two lower slices it holds the accumulated voltage and steps a current-scale code so that each further slice counts one eighth as much as the slice before it. A final strobe follows the low slice, and a one-cycle completion pulse closes the pass. Each logical row fans out to four physical word lines that carry replicated weight cells.

Top module: `wl_slice_seq`

## Requirements
- R1: A high `start` seen at a rising edge while idle registers `actIn` and begins a pass; `capReset` is high for exactly the one cycle after that edge, and the pass then uses only the registered activations.
- R2: Slices are applied in the order activation bits [7:6], then [5:3], then [2:0]. Row r takes its activation from `actIn[8r+7:8r]`.
- R3: Within a phase, a row's word lines are high for the first V cycles of the phase, where V is that row's slice value. A slice of zero keeps them low for the whole phase.
- R4: The phases last a fixed 4, 8 and 8 cycles for the high, middle and low slices, whatever the data. This is the largest pulse for the slice width plus one guard cycle.
- R5: Logical row r drives `wordLine[4r+3:4r]`, all four bits equal. Rows pulse at the same time and do not affect each other.
- R6: `adcSample` is high for one cycle right after the high phase and for one cycle right after the low phase. No word line is high while `capReset`, `adcSample` or `accHold` is high.
- R7: `accHold` is high for one cycle right before the middle phase and one cycle right before the low phase. `scaleSel` is 0 from reset through the first sample, 1 from the first hold through the middle phase, and 2 from the second hold through the final sample. It changes only on a hold cycle or a `done` cycle.
- R8: `done` is a single-cycle pulse in the cycle right after the final `adcSample`. A pass covers 26 cycles after the start edge, and the block is idle again on the next cycle.
- R9: `start` is ignored while a pass runs, including the `done` cycle. It changes neither the timing nor the registered activations.
- R10: During and after reset, all word lines and control outputs are low and `scaleSel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pass request, honoured only while idle |
| actIn | input | NUM_ROWS*8 | Activation vector, 8 bits per logical row |
| wordLine | output | NUM_ROWS*4 | Physical word-line enables, 4 per logical row |
| capReset | output | 1 | Accumulator capacitor clear |
| adcSample | output | 1 | Converter sample strobe |
| accHold | output | 1 | Accumulator hold between slices |
| scaleSel | output | 2 | Current-scale code: 0 = unity, 1 = 1/8, 2 = 1/64 |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The functions most likely to collide are a new `start` request and a running pass. The sharpest case is a request that arrives on the `done` cycle or during a sample strobe. The bench raises `start` with an inverted activation vector in the middle of a phase, on the first sample and on the `done` cycle. It then compares every output in every cycle against the schedule worked out from the original vector, and checks that the block is idle on the following cycle. A sweep over 256 activation patterns on four rows covers every slice value in every phase, including all-zero and all-ones slices that meet the guard cycle.

// File: rtl/wl_slice_pkg.sv
package wl_slice_pkg;
  localparam int MS_W   = 2;
  localparam int MID_W  = 3;
  localparam int LS_W   = 3;
  localparam int ACT_W  = MS_W + MID_W + LS_W;
  localparam int SL_MAX = 3;
  localparam int CNT_W  = SL_MAX;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_PH, ST_SMP, ST_HOLD, ST_DONE
  } seqState_e;

  typedef struct packed {
    logic             loadAct;
    logic             pulseEn;
    logic [1:0]       sliceIdx;
    logic [CNT_W-1:0] cnt;
  } seqCtrl_s;

  function automatic logic [CNT_W-1:0] lastCnt(input logic [1:0] idx);
    case (idx)
      2'd0:    lastCnt = CNT_W'((1 << MS_W) - 1);
      2'd1:    lastCnt = CNT_W'((1 << MID_W) - 1);
      default: lastCnt = CNT_W'((1 << LS_W) - 1);
    endcase
  endfunction
endpackage

// File: rtl/wl_slice_ctrl.sv
module wl_slice_ctrl
  import wl_slice_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output seqCtrl_s   ctrl,
  output logic       capReset,
  output logic       adcSample,
  output logic       accHold,
  output logic [1:0] scaleSel,
  output logic       done
);
  seqState_e        state, stateNxt;
  logic [1:0]       idx, idxNxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  always_comb begin
    stateNxt = state;
    idxNxt   = idx;
    cntNxt   = cnt;
    case (state)
      ST_IDLE: if (start) begin
        stateNxt = ST_RST;
        idxNxt   = 2'd0;
      end
      ST_RST: begin
        stateNxt = ST_PH;
        cntNxt   = '0;
      end
      ST_PH: begin
        if (cnt == lastCnt(idx)) begin
          if (idx == 2'd1) begin
            stateNxt = ST_HOLD;
            idxNxt   = 2'd2;
          end else begin
            stateNxt = ST_SMP;
          end
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_SMP: begin
        if (idx == 2'd0) begin
          stateNxt = ST_HOLD;
          idxNxt   = 2'd1;
        end else begin
          stateNxt = ST_DONE;
        end
      end
      ST_HOLD: begin
        stateNxt = ST_PH;
        cntNxt   = '0;
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      idx   <= idxNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    ctrl.loadAct  = (state == ST_IDLE) && start;
    ctrl.pulseEn  = (state == ST_PH);
    ctrl.sliceIdx = idx;
    ctrl.cnt      = cnt;
    capReset      = (state == ST_RST);
    adcSample     = (state == ST_SMP);
    accHold       = (state == ST_HOLD);
    done          = (state == ST_DONE);
    scaleSel      = (state == ST_IDLE || state == ST_DONE) ? 2'd0 : idx;
  end
endmodule

// File: rtl/wl_slice_dp.sv
module wl_slice_dp
  import wl_slice_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int REPL     = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  seqCtrl_s                  ctrl,
  input  logic [NUM_ROWS*ACT_W-1:0] actIn,
  output logic [NUM_ROWS*REPL-1:0]  wordLine
);
  localparam int LS_LO  = 0;
  localparam int MID_LO = LS_W;
  localparam int MS_LO  = LS_W + MID_W;

  logic [NUM_ROWS*ACT_W-1:0] actReg;

  always_ff @(posedge clk) begin
    if (rst)               actReg <= '0;
    else if (ctrl.loadAct) actReg <= actIn;
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic [ACT_W-1:0]  act;
    logic [SL_MAX-1:0] sliceVal;
    logic              rowOn;

    assign act = actReg[r*ACT_W +: ACT_W];

    always_comb begin
      case (ctrl.sliceIdx)
        2'd0:    sliceVal = SL_MAX'(act[MS_LO +: MS_W]);
        2'd1:    sliceVal = SL_MAX'(act[MID_LO +: MID_W]);
        default: sliceVal = SL_MAX'(act[LS_LO +: LS_W]);
      endcase
      rowOn = ctrl.pulseEn && (ctrl.cnt < sliceVal);
    end

    assign wordLine[r*REPL +: REPL] = {REPL{rowOn}};
  end
endmodule

// File: rtl/wl_slice_seq.sv
module wl_slice_seq
  import wl_slice_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int REPL     = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [NUM_ROWS*ACT_W-1:0] actIn,
  output logic [NUM_ROWS*REPL-1:0]  wordLine,
  output logic                      capReset,
  output logic                      adcSample,
  output logic                      accHold,
  output logic [1:0]                scaleSel,
  output logic                      done
);
  seqCtrl_s ctrl;

  wl_slice_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .ctrl(ctrl),
    .capReset(capReset), .adcSample(adcSample), .accHold(accHold),
    .scaleSel(scaleSel), .done(done)
  );

  wl_slice_dp #(.NUM_ROWS(NUM_ROWS), .REPL(REPL)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .actIn(actIn), .wordLine(wordLine)
  );
endmodule

// File: rtl/wl_slice_chk.sv
module wl_slice_chk #(
  parameter int NUM_ROWS = 4,
  parameter int REPL     = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_ROWS*REPL-1:0] wordLine,
  input logic                     capReset,
  input logic                     adcSample,
  input logic                     accHold,
  input logic [1:0]               scaleSel,
  input logic                     done
);
  p_reset_sample_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(capReset && adcSample));

  p_quiet_wl_r6: assert property (@(posedge clk) disable iff (rst)
    (capReset || adcSample || accHold) |-> (wordLine == '0));

  p_reset_single_r1: assert property (@(posedge clk) disable iff (rst)
    capReset |=> !capReset);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_sample_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(adcSample));

  p_scale_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(scaleSel) |-> (accHold || done));

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_grp
    p_repl_group_r5: assert property (@(posedge clk) disable iff (rst)
      $countones(wordLine[r*REPL +: REPL]) == 0 ||
      $countones(wordLine[r*REPL +: REPL]) == REPL);
  end
endmodule

bind wl_slice_seq wl_slice_chk #(.NUM_ROWS(NUM_ROWS), .REPL(REPL)) u_chk (
  .clk(clk), .rst(rst), .wordLine(wordLine), .capReset(capReset),
  .adcSample(adcSample), .accHold(accHold), .scaleSel(scaleSel), .done(done)
);

// File: tb/tb_wl_slice_seq.sv
module tb_wl_slice_seq;
  localparam int NR = 4;
  localparam int RP = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [NR*8-1:0]  actIn = '0;
  logic [NR*RP-1:0] wordLine;
  logic             capReset, adcSample, accHold, done;
  logic [1:0]       scaleSel;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wl_slice_seq #(.NUM_ROWS(NR), .REPL(RP)) dut (
    .clk(clk), .rst(rst), .start(start), .actIn(actIn), .wordLine(wordLine),
    .capReset(capReset), .adcSample(adcSample), .accHold(accHold),
    .scaleSel(scaleSel), .done(done)
  );

  // Expected outputs t cycles after the start edge (t = 0 means idle).
  function automatic logic [NR*RP+5-1:0] expAt(input int t, input logic [NR*8-1:0] act);
    logic [NR*RP-1:0] wl;
    logic cr, sm, hd, dn;
    logic [1:0] sc;
    wl = '0; cr = 0; sm = 0; hd = 0; dn = 0; sc = 2'd0;
    for (int r = 0; r < NR; r++) begin
      int v;
      int c;
      v = -1; c = 0;
      if (t >= 2 && t <= 5)   begin v = int'(act[r*8+6 +: 2]); c = t - 2;  end
      if (t >= 8 && t <= 15)  begin v = int'(act[r*8+3 +: 3]); c = t - 8;  end
      if (t >= 17 && t <= 24) begin v = int'(act[r*8   +: 3]); c = t - 17; end
      if (v >= 0 && c < v) wl[r*RP +: RP] = '1;
    end
    cr = (t == 1);
    sm = (t == 6 || t == 25);
    hd = (t == 7 || t == 16);
    dn = (t == 26);
    if (t >= 7 && t <= 15)  sc = 2'd1;
    if (t >= 16 && t <= 25) sc = 2'd2;
    return {wl, cr, sm, hd, dn, sc[0]} ^ {{(NR*RP+4){1'b0}}, 1'b0} | '0 | {{(NR*RP+4){1'b0}}, 1'b0}
           | ({wl, cr, sm, hd, dn, 1'b0} & '0) | {wl, cr, sm, hd, dn, 1'b0} | {{(NR*RP+4){1'b0}}, sc[0]};
  endfunction

  function automatic logic [1:0] expScale(input int t);
    if (t >= 7 && t <= 15)  return 2'd1;
    if (t >= 16 && t <= 25) return 2'd2;
    return 2'd0;
  endfunction

  task automatic checkCycle(input int t, input logic [NR*8-1:0] act, input string req);
    logic [NR*RP+5-1:0] e, a;
    logic [1:0] es;
    e  = expAt(t, act);
    es = expScale(t);
    a  = {wordLine, capReset, adcSample, accHold, done, scaleSel[0]};
    checks++;
    if (a !== e || scaleSel !== es) begin
      fails++;
      $display("FAIL %s t=%0d act=%h: got wl=%h cr%b sm%b hd%b dn%b sc%0d, expected wl=%h cr%b sm%b hd%b dn%b sc%0d",
               req, t, act, wordLine, capReset, adcSample, accHold, done, scaleSel,
               e[NR*RP+4 -: NR*RP], e[4], e[3], e[2], e[1], es);
    end
  endtask

  // glitchMask bit k: raise start with a corrupted vector at offset k.
  task automatic runPass(input logic [NR*8-1:0] act, input logic [31:0] glitchMask, input string req);
    @(negedge clk);
    start = 1'b1;
    actIn = act;
    @(negedge clk);
    start = 1'b0;
    for (int t = 1; t <= 26; t++) begin
      checkCycle(t, act, req);
      if (glitchMask[t]) begin
        start = 1'b1;
        actIn = ~act;
      end
      @(negedge clk);
      start = 1'b0;
    end
    checkCycle(0, act, "R8 idle after pass");
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs quiet during reset
    checkCycle(0, '0, "R10 in reset");
    rst = 1'b0;
    @(negedge clk);
    checkCycle(0, '0, "R10 after reset");

    // R3 zero slices, R4 fixed timing
    runPass('0, 32'h0, "R3 R4 all zero");
    // R3 maximum slices meet the guard cycle
    runPass('1, 32'h0, "R3 R4 all ones");
    // R2 slice order: distinct slice per row
    runPass({8'b11_000_000, 8'b00_111_000, 8'b00_000_111, 8'b10_101_011}, 32'h0, "R2 slice order");
    // R5 rows independent
    runPass({8'h00, 8'hFF, 8'h00, 8'h49}, 32'h0, "R5 row independence");
    // R9 start mid-phase, on first sample, and on done cycle
    runPass({8'h5A, 8'hC3, 8'h18, 8'h97}, (32'b1 << 3) | (32'b1 << 6) | (32'b1 << 12) | (32'b1 << 26),
            "R9 start ignored while busy");
    // R1 new vector after an ignored request is taken on the next idle start
    runPass({8'h01, 8'h40, 8'h08, 8'hB6}, 32'h0, "R1 fresh load");

    // Sweep: R3 R6 R7 every slice value in every row
    for (int v = 0; v < 256; v++) begin
      logic [7:0] a0, a1, a2, a3;
      a0 = 8'(v);
      a1 = 8'(255 - v);
      a2 = 8'(v) ^ 8'h5A;
      a3 = 8'(v * 37);
      runPass({a3, a2, a1, a0}, 32'h0, "R3 R6 R7 sweep");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule